// File: doc/BRIEF.md
# Extended Control-Register Move Unit

This block executes the 32-bit extended form of a compressed instruction that copies a general-purpose register into a system-control register. It checks the fixed fields of the instruction word and maps the 3-bit source index onto a general-register number. It decides whether the addressed control register exists, raises an exception where one applies, and issues a 64-bit write on a control-register write port.

On a 64-bit write, the upper 32 bits are forced to zero for a few specific registers, depending on three configuration flags: an extended-upper-half flag, a large-physical-address flag and a virtualization flag. Two read-only registers are never changed. They receive the strobe with both half-enables low.

The source value must be presented on `src_data` in the same cycle as `ins_valid`. It is read from the general register named by `gpr_idx`, which is combinational from `ins_word`. Every result (write or exception) appears as a one-cycle pulse on the clock edge that samples `ins_valid`.

The controller has three states:
- `ST_IDLE`: nothing issued.
- `ST_WRITE`: write strobe active.
- `ST_FAULT`: one exception flag active.

Each clock edge moves the controller as follows:
- Any state goes to `ST_FAULT` when the sampled instruction excepts.
- Any state goes to `ST_WRITE` when the sampled instruction addresses an implemented register.
- In every other case the controller returns to `ST_IDLE`.

Back-to-back instructions are accepted every cycle.

Top module: `cpmv_unit`

## Requirements
- R1: The instruction word, from bit 31 down, is: prefix `11110` [31:27], zero field `000` [26:24], select [23:21], subop `00001` [20:16], opcode `01100` [15:11], function `111` [10:8], source index [7:5], destination register [4:0]. If any fixed field differs, or `ext_isa_en` is 0, `exc_ri` pulses and no write occurs.
- R2: If `kernel_mode` is 0 and `cu0_usable` is 0, `exc_cpu` pulses and no write occurs. When both exceptions apply, only `exc_ri` is raised.
- R3: `gpr_idx` maps source index 0..7 to general registers 16, 17, 2, 3, 4, 5, 6, 7.
- R4: A register (reg, sel) is implemented when sel is 0, or when it is (17,1), or when reg is 28 and sel is even. A valid instruction addressing any other pair produces no strobe and no exception.
- R5: For a valid, non-excepting instruction addressing an implemented register, `wr_stb` is high for exactly the one cycle after the sampling edge. In that cycle `wr_reg`/`wr_sel` match the instruction and, unless R9 applies, both half-enables are 1.
- R6: When `cfg_ext_hi` and `cfg_large_pa` are both 1, a write to (2,0), (3,0) or (17,1) has `wr_data[63:32]` forced to 0. Otherwise it carries `src_data` unchanged.
- R7: When `cfg_ext_hi` is 1, a write to register 28 with an even select has `wr_data[63:32]` forced to 0.
- R8: When `cfg_ext_hi` and `cfg_virt` are both 1, a write to (10,0) has `wr_data[63:32]` forced to 0.
- R9: The read-only registers (8,0) and (17,0) receive the strobe with `wr_lo_en` and `wr_hi_en` both 0. Their data is never zeroed.
- R10: After reset, and in every cycle following one without `ins_valid`, `wr_stb`, `exc_ri` and `exc_cpu` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_word | input | 32 | Extended instruction word |
| src_data | input | 64 | Value of the general register named by gpr_idx |
| kernel_mode | input | 1 | Instruction runs in kernel mode |
| cu0_usable | input | 1 | Control coprocessor usable bit |
| ext_isa_en | input | 1 | Extended compressed instruction set enabled |
| cfg_ext_hi | input | 1 | Extended upper-half write behaviour enabled |
| cfg_large_pa | input | 1 | Large physical addressing enabled |
| cfg_virt | input | 1 | Virtualization support present |
| gpr_idx | output | 5 | Translated general-register number |
| wr_stb | output | 1 | Control-register write strobe |
| wr_reg | output | 5 | Destination register number |
| wr_sel | output | 3 | Destination select |
| wr_data | output | 64 | Write data |
| wr_lo_en | output | 1 | Enable for bits 31:0 |
| wr_hi_en | output | 1 | Enable for bits 63:32 |
| exc_ri | output | 1 | Reserved-instruction exception pulse |
| exc_cpu | output | 1 | Coprocessor-unusable exception pulse |

## Verification
A wrong next-state choice shows on the very next cycle, in one of three ways:
- a missing or extra `wr_stb` pulse;
- a pulse that lasts two cycles;
- a write and an exception raised together.

A wrong captured payload shows in that same strobe cycle as a mismatched register, select, half-enable or upper data word. The stimulus table covers each zeroing rule with its enabling flags both on and partly off. This makes a flag dropped from a condition visible on a single instruction.

// File: rtl/cpmv_pkg.sv
package cpmv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FAULT = 2'd2
    } mv_state_t;

    localparam logic [4:0] PFX_VAL   = 5'b11110;
    localparam logic [2:0] ZERO_VAL  = 3'b000;
    localparam logic [4:0] SUBOP_VAL = 5'b00001;
    localparam logic [4:0] OPC_VAL   = 5'b01100;
    localparam logic [2:0] FUNC_VAL  = 3'b111;

    localparam logic [4:0] RN_XLO0   = 5'd2;
    localparam logic [4:0] RN_XLO1   = 5'd3;
    localparam logic [4:0] RN_FAULTA = 5'd8;
    localparam logic [4:0] RN_XHI    = 5'd10;
    localparam logic [4:0] RN_LINKA  = 5'd17;
    localparam logic [4:0] RN_CTAG   = 5'd28;
endpackage

// File: rtl/cpmv_decode.sv
module cpmv_decode
    import cpmv_pkg::*;
(
    input  logic [31:0] word,
    input  logic        ext_en,
    output logic [2:0]  sel,
    output logic [4:0]  dst,
    output logic [4:0]  gpr,
    output logic        bad
);
    logic [2:0] src_i;

    assign sel   = word[23:21];
    assign dst   = word[4:0];
    assign src_i = word[7:5];

    // R1: fixed-field check
    assign bad = !ext_en
              || (word[31:27] != PFX_VAL)
              || (word[26:24] != ZERO_VAL)
              || (word[20:16] != SUBOP_VAL)
              || (word[15:11] != OPC_VAL)
              || (word[10:8]  != FUNC_VAL);

    // R3: index translation
    always_comb begin
        unique case (src_i)
            3'd0:    gpr = 5'd16;
            3'd1:    gpr = 5'd17;
            default: gpr = {2'b00, src_i};
        endcase
    end
endmodule

// File: rtl/cpmv_policy.sv
module cpmv_policy
    import cpmv_pkg::*;
(
    input  logic [4:0] dst,
    input  logic [2:0] sel,
    input  logic       ext_hi,
    input  logic       large_pa,
    input  logic       virt,
    output logic       implemented,
    output logic       read_only,
    output logic       zero_hi
);
    logic s0, is_xlo, is_attr, is_tag, is_xhi;

    assign s0      = (sel == 3'd0);
    assign is_xlo  = s0 && (dst == RN_XLO0 || dst == RN_XLO1);
    assign is_attr = (dst == RN_LINKA) && (sel == 3'd1);
    assign is_tag  = (dst == RN_CTAG) && !sel[0];
    assign is_xhi  = s0 && (dst == RN_XHI);

    assign implemented = s0 || is_attr || is_tag;                               // R4
    assign read_only   = s0 && (dst == RN_FAULTA || dst == RN_LINKA);           // R9
    assign zero_hi     = ext_hi && ((large_pa && (is_xlo || is_attr))           // R6
                                    || is_tag                                   // R7
                                    || (virt && is_xhi));                       // R8
endmodule

// File: rtl/cpmv_unit.sv
module cpmv_unit
    import cpmv_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [31:0]       ins_word,
    input  logic [DATA_W-1:0] src_data,
    input  logic              kernel_mode,
    input  logic              cu0_usable,
    input  logic              ext_isa_en,
    input  logic              cfg_ext_hi,
    input  logic              cfg_large_pa,
    input  logic              cfg_virt,
    output logic [4:0]        gpr_idx,
    output logic              wr_stb,
    output logic [4:0]        wr_reg,
    output logic [2:0]        wr_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_lo_en,
    output logic              wr_hi_en,
    output logic              exc_ri,
    output logic              exc_cpu
);
    localparam int HALF_W = DATA_W / 2;

    logic [2:0] d_sel;
    logic [4:0] d_dst;
    logic       d_bad, p_impl, p_ro, p_zero, cpu_bad;

    cpmv_decode u_dec (
        .word(ins_word), .ext_en(ext_isa_en),
        .sel(d_sel), .dst(d_dst), .gpr(gpr_idx), .bad(d_bad)
    );

    cpmv_policy u_pol (
        .dst(d_dst), .sel(d_sel), .ext_hi(cfg_ext_hi), .large_pa(cfg_large_pa),
        .virt(cfg_virt), .implemented(p_impl), .read_only(p_ro), .zero_hi(p_zero)
    );

    assign cpu_bad = !kernel_mode && !cu0_usable;

    mv_state_t state_q, state_d;
    logic      ri_q, ro_q;

    always_comb begin
        state_d = ST_IDLE;
        if (ins_valid) begin
            if (d_bad || cpu_bad)
                state_d = ST_FAULT;
            else if (p_impl)
                state_d = ST_WRITE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_reg  <= '0;
            wr_sel  <= '0;
            wr_data <= '0;
            ri_q    <= 1'b0;
            ro_q    <= 1'b0;
        end else if (ins_valid) begin
            wr_reg  <= d_dst;
            wr_sel  <= d_sel;
            wr_data <= {(p_zero ? {HALF_W{1'b0}} : src_data[DATA_W-1:HALF_W]),
                        src_data[HALF_W-1:0]};
            ri_q    <= d_bad;
            ro_q    <= p_ro;
        end
    end

    always_comb begin
        wr_stb   = 1'b0;
        wr_lo_en = 1'b0;
        wr_hi_en = 1'b0;
        exc_ri   = 1'b0;
        exc_cpu  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE: begin
                wr_stb   = 1'b1;
                wr_lo_en = !ro_q;
                wr_hi_en = !ro_q;
            end
            ST_FAULT: begin
                exc_ri  = ri_q;
                exc_cpu = !ri_q;
            end
            default: ;
        endcase
    end

    a_r2_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, exc_ri, exc_cpu}));

    a_r5_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(ins_valid));

    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ins_valid) |-> (!wr_stb && !exc_ri && !exc_cpu));

    a_r4_sel_impl: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel != 3'd0) |->
        ((wr_reg == RN_LINKA && wr_sel == 3'd1) || (wr_reg == RN_CTAG && !wr_sel[0])));

    a_r9_ro_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == 3'd0 && (wr_reg == RN_FAULTA || wr_reg == RN_LINKA))
        |-> (!wr_lo_en && !wr_hi_en));

    a_r6_xlo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_reg == RN_XLO0 && wr_sel == 3'd0 && $past(cfg_ext_hi && cfg_large_pa))
        |-> (wr_data[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/cpmv_unit_test.sv
`timescale 1ns/1ps
module cpmv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_word = '0;
    logic [63:0] src_data = '0;
    logic        kernel_mode = 1'b1, cu0_usable = 1'b1, ext_isa_en = 1'b1;
    logic        cfg_ext_hi = 1'b0, cfg_large_pa = 1'b0, cfg_virt = 1'b0;
    logic [4:0]  gpr_idx, wr_reg;
    logic [2:0]  wr_sel;
    logic [63:0] wr_data;
    logic        wr_stb, wr_lo_en, wr_hi_en, exc_ri, exc_cpu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpmv_unit uut (.*);

    localparam logic [63:0] SRC = 64'hDEAD_BEEF_1234_5678;

    // {sel, reg, ext_hi large_pa virt, exp_stb exp_en exp_zero}
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {3'd0, 5'd2,  3'b110, 3'b111},  // R6
        {3'd0, 5'd3,  3'b100, 3'b110},  // R6 flag off
        {3'd1, 5'd17, 3'b110, 3'b111},  // R6
        {3'd2, 5'd28, 3'b100, 3'b111},  // R7
        {3'd0, 5'd28, 3'b000, 3'b110},  // R7 flag off
        {3'd0, 5'd10, 3'b101, 3'b111},  // R8
        {3'd0, 5'd10, 3'b011, 3'b110},  // R8 flag off
        {3'd0, 5'd17, 3'b111, 3'b100},  // R9
        {3'd0, 5'd8,  3'b111, 3'b100},  // R9
        {3'd3, 5'd5,  3'b111, 3'b000},  // R4
        {3'd3, 5'd28, 3'b111, 3'b000},  // R4
        {3'd0, 5'd12, 3'b111, 3'b110}   // R5
    };

    function automatic logic [31:0] mk(input logic [2:0] s, input logic [2:0] i,
                                       input logic [4:0] r);
        return {5'b11110, 3'b000, s, 5'b00001, 5'b01100, 3'b111, i, r};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge (one posedge between)
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        ins_word  = w;
        src_data  = SRC;
        ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_stb && !exc_ri && !exc_cpu, "R10 reset", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_stb && !exc_ri && !exc_cpu, "R10 idle", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd0);

        for (int k = 0; k < NV; k++) begin
            logic [63:0] exp_d;
            {cfg_ext_hi, cfg_large_pa, cfg_virt} = VEC[k][5:3];
            issue(mk(VEC[k][13:11], 3'd2, VEC[k][10:6]));
            exp_d = VEC[k][0] ? {32'd0, SRC[31:0]} : SRC;
            chk(wr_stb == VEC[k][2] && !exc_ri && !exc_cpu, "R4/R5 strobe",
                {63'd0, wr_stb}, {63'd0, VEC[k][2]});
            if (VEC[k][2]) begin
                chk(wr_reg == VEC[k][10:6] && wr_sel == VEC[k][13:11], "R5 target",
                    {56'd0, wr_sel, wr_reg}, {56'd0, VEC[k][13:6]});
                chk(wr_lo_en == VEC[k][1] && wr_hi_en == VEC[k][1], "R9 enables",
                    {62'd0, wr_hi_en, wr_lo_en}, {62'd0, VEC[k][1], VEC[k][1]});
                chk(wr_data == exp_d, "R6/R7/R8 data", wr_data, exp_d);
            end
            @(negedge clk);
            chk(!wr_stb, "R5 single pulse", {63'd0, wr_stb}, 64'd0);
        end

        // R3 translation
        for (int i = 0; i < 8; i++) begin
            logic [4:0] e;
            e = (i == 0) ? 5'd16 : (i == 1) ? 5'd17 : 5'(i);
            ins_word = mk(3'd0, 3'(i), 5'd12);
            #1;
            chk(gpr_idx == e, "R3 translate", {59'd0, gpr_idx}, {59'd0, e});
        end

        // R1 bad fixed field
        issue(mk(3'd0, 3'd0, 5'd12) ^ 32'h0000_0400);
        chk(exc_ri && !exc_cpu && !wr_stb, "R1 bad field", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd2);
        issue(mk(3'd0, 3'd0, 5'd12) ^ 32'h8000_0000);
        chk(exc_ri && !wr_stb, "R1 bad prefix", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd2);
        ext_isa_en = 1'b0;
        issue(mk(3'd0, 3'd0, 5'd12));
        chk(exc_ri && !wr_stb, "R1 ext disabled", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd2);
        ext_isa_en = 1'b1;

        // R2 unusable, priority, kernel override
        kernel_mode = 1'b0; cu0_usable = 1'b0;
        issue(mk(3'd0, 3'd0, 5'd12));
        chk(exc_cpu && !exc_ri && !wr_stb, "R2 unusable", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd1);
        @(negedge clk);
        chk(!exc_cpu, "R2 one-cycle pulse", {63'd0, exc_cpu}, 64'd0);
        ext_isa_en = 1'b0;
        issue(mk(3'd0, 3'd0, 5'd12));
        chk(exc_ri && !exc_cpu, "R2 RI priority", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd2);
        ext_isa_en = 1'b1;
        cu0_usable = 1'b1;
        issue(mk(3'd0, 3'd0, 5'd12));
        chk(wr_stb && !exc_cpu, "R2 usable bit set", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd4);
        kernel_mode = 1'b1; cu0_usable = 1'b0;
        issue(mk(3'd0, 3'd0, 5'd12));
        chk(wr_stb && !exc_cpu, "R2 kernel mode", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd4);

        // R10 no valid -> nothing
        ins_word = mk(3'd0, 3'd0, 5'd12);
        repeat (2) @(negedge clk);
        chk(!wr_stb && !exc_ri && !exc_cpu, "R10 no valid", {61'd0, wr_stb, exc_ri, exc_cpu}, 64'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule